// File: doc/BRIEF.md
# Prescaled PWM Channel

This block is one pulse-width-modulated output with a byte-wide register port (address, write data, write strobe, combinational read data). Three clock-enable inputs mark ticks of a slow, a medium and a fast reference clock. The channel selects one of them and divides it by a predivider (1, 3, 5 or 6) times 2 to the power of an exponent (0 to 7). Each divided step advances a frame counter of 6 or 9 bits, and the output is high while the counter is below the duty value.

Software writes resolution, clock choice, divider and duty into staging registers. None of these touch the output until a commit register is written. With the deferred-update mode off, the commit applies at once and restarts the frame. With it on, the commit waits for the end of the running frame, so no frame is ever cut short. The output-enable bit, the source-select bit and the deferred-update bit are not staged and act at once. When the source bit is clear, an external pattern input is passed to the output in place of the generator.

A build parameter holds the read-only identity byte. That byte also sets which bit of the resolution register carries the resolution select.

Top module: `prescaled_pwm_chan`

## Requirements
- R1: After reset every writable register reads 0, the identity register at 0x05 reads the `SUBTYPE_ID` parameter (default 0x11), and `pwm_out` is 0.
- R2: Register map: 0x41 holds the resolution bit and clock select [1:0]; 0x42 holds predivider code [6:5] and exponent [2:0]; 0x43 bit 5 is deferred update; 0x44 is duty [7:0]; 0x45 bit 0 is duty bit 8; 0x46 holds enable (bit 7), source (bit 2) and a stored ramp bit (bit 1). Unused bits read 0. Offset 0x47 and every unmapped offset read 0. Writes to 0x05 are ignored.
- R3: The resolution bit sits at bit 2 of 0x41 when `SUBTYPE_ID` is 0x0B, and at bit 4 for any other identity. The other position is neither stored nor read back.
- R4: Staged resolution, clock select, divider and duty have no effect on the output until bit 0 of 0x47 is written with 1.
- R5: With deferred update off, the commit write's clock edge loads the staged settings and clears the divider and frame counters, so the frame restarts in the next cycle.
- R6: With deferred update on, a commit loads the settings at the next frame wrap. If the active clock select is 0, or deferred update has been turned off, it loads at once.
- R7: The output period is 2^size x predivider x 2^exponent selected ticks. Size is 6 (resolution bit 0) or 9 (bit 1). Predivider codes 0, 1, 2, 3 mean 1, 3, 5, 6.
- R8: Clock select 1 uses `tick_slow`, 2 uses `tick_mid`, 3 uses `tick_fast`, and 0 freezes the divider and frame counter.
- R9: In generator mode the output is high while the frame counter is below the duty value masked to the low size bits. So 2^size-1 gives one low tick per frame, and 0 or 2^size gives no high ticks.
- R10: The output is 0 while the enable bit is 0. With enable 1 and source 0, `pwm_out` equals `pattern_in`.
- R11: The ramp bit is stored and read back and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_slow | input | 1 | Slow reference clock enable |
| tick_mid | input | 1 | Medium reference clock enable |
| tick_fast | input | 1 | Fast reference clock enable |
| pattern_in | input | 1 | External pattern level used when source is 0 |
| pwm_out | output | 1 | Channel output |

## Verification
The assertions watch, on every cycle, the relations that hold at any instant:
- a disabled output stays low;
- pattern mode follows its input;
- the last slot of a frame is always low;
- the frame counter never passes its wrap value and holds still when no clock is selected;
- a deferred commit lands only on a wrap, and any commit restarts the frame;
- unmapped offsets read 0.

Only the bench's scenarios can show the quantities built up over whole frames. These are the period for each predivider, exponent and clock choice, the count of high ticks for a given duty, and the point of a staged change's first frame. The bench's reference model checks these against the output on every clock.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int CSEL_W  = 2;
    localparam int PDIV_W  = 2;
    localparam int EXP_W   = 3;
    localparam int SIZE_LO = 6;
    localparam int SIZE_HI = 9;
    localparam int DUTY_W  = SIZE_HI;
    localparam int CNT_W   = SIZE_HI;
    localparam int PDIV_MAX = 6;
    localparam int DIV_MAX  = PDIV_MAX << ((1 << EXP_W) - 1);
    localparam int PSC_W    = $clog2(DIV_MAX);

    localparam logic [7:0] OFS_IDENT   = 8'h05;
    localparam logic [7:0] OFS_RES     = 8'h41;
    localparam logic [7:0] OFS_DIV     = 8'h42;
    localparam logic [7:0] OFS_MODE    = 8'h43;
    localparam logic [7:0] OFS_DUTY_LO = 8'h44;
    localparam logic [7:0] OFS_DUTY_HI = 8'h45;
    localparam logic [7:0] OFS_CTRL    = 8'h46;
    localparam logic [7:0] OFS_COMMIT  = 8'h47;
    localparam logic [7:0] IDENT_NARROW = 8'h0B;

    typedef struct packed {
        logic              wide;
        logic [CSEL_W-1:0] csel;
        logic [PDIV_W-1:0] pdiv;
        logic [EXP_W-1:0]  expo;
        logic [DUTY_W-1:0] duty;
    } chan_cfg_t;

    function automatic logic [2:0] pdiv_factor(input logic [PDIV_W-1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd3;
            2'd2:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] frame_last(input logic wide);
        return wide ? CNT_W'((1 << SIZE_HI) - 1) : CNT_W'((1 << SIZE_LO) - 1);
    endfunction
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_chan_pkg::*;
#(
    parameter logic [7:0] SUBTYPE_ID = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    input  logic       frame_wrap,
    output chan_cfg_t  act_cfg,
    output logic       out_en,
    output logic       src_pwm,
    output logic       glitch_en,
    output logic       commit,
    output logic [7:0] reg_rdata
);
    localparam int SIZE_BIT = (SUBTYPE_ID == IDENT_NARROW) ? 2 : 4;

    typedef struct packed {
        chan_cfg_t stg;
        chan_cfg_t act;
        logic      glitch;
        logic      en;
        logic      src;
        logic      ramp;
        logic      pend;
    } regs_st_t;

    regs_st_t s_q, s_d;
    logic     sync_wr, take_now, clk_stopped;

    always_comb begin
        s_d         = s_q;
        sync_wr     = reg_we && (reg_addr == OFS_COMMIT) && reg_wdata[0];
        clk_stopped = (s_q.act.csel == '0);
        take_now    = sync_wr && (!s_q.glitch || clk_stopped);
        commit      = take_now || (s_q.pend && (frame_wrap || !s_q.glitch || clk_stopped));

        if (commit) begin
            s_d.act  = s_q.stg;
            s_d.pend = 1'b0;
        end else if (sync_wr) begin
            s_d.pend = 1'b1;
        end

        if (reg_we) begin
            case (reg_addr)
                OFS_RES: begin
                    s_d.stg.wide = reg_wdata[SIZE_BIT];
                    s_d.stg.csel = reg_wdata[CSEL_W-1:0];
                end
                OFS_DIV: begin
                    s_d.stg.pdiv = reg_wdata[6:5];
                    s_d.stg.expo = reg_wdata[EXP_W-1:0];
                end
                OFS_MODE:    s_d.glitch = reg_wdata[5];
                OFS_DUTY_LO: s_d.stg.duty[7:0] = reg_wdata;
                OFS_DUTY_HI: s_d.stg.duty[DUTY_W-1] = reg_wdata[0];
                OFS_CTRL: begin
                    s_d.en   = reg_wdata[7];
                    s_d.src  = reg_wdata[2];
                    s_d.ramp = reg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_IDENT: reg_rdata = SUBTYPE_ID;
            OFS_RES: begin
                reg_rdata[SIZE_BIT]     = s_q.stg.wide;
                reg_rdata[CSEL_W-1:0]   = s_q.stg.csel;
            end
            OFS_DIV:     reg_rdata = {1'b0, s_q.stg.pdiv, 2'b00, s_q.stg.expo};
            OFS_MODE:    reg_rdata = {2'b00, s_q.glitch, 5'b00000};
            OFS_DUTY_LO: reg_rdata = s_q.stg.duty[7:0];
            OFS_DUTY_HI: reg_rdata = {7'b0, s_q.stg.duty[DUTY_W-1]};
            OFS_CTRL:    reg_rdata = {s_q.en, 4'b0000, s_q.src, s_q.ramp, 1'b0};
            default:     reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_cfg   = s_q.act;
    assign out_en    = s_q.en;
    assign src_pwm   = s_q.src;
    assign glitch_en = s_q.glitch;
endmodule

// File: rtl/pwm_chan_prescale.sv
module pwm_chan_prescale
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_mid,
    input  logic              tick_fast,
    input  logic [CSEL_W-1:0] csel,
    input  logic [PDIV_W-1:0] pdiv,
    input  logic [EXP_W-1:0]  expo,
    input  logic              clear,
    output logic              step
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t          p_q, p_d;
    logic             tick;
    logic [PSC_W-1:0] div_n, div_last;

    always_comb begin
        case (csel)
            2'd1:    tick = tick_slow;
            2'd2:    tick = tick_mid;
            2'd3:    tick = tick_fast;
            default: tick = 1'b0;
        endcase
        div_n    = PSC_W'(pdiv_factor(pdiv)) << expo;
        div_last = div_n - PSC_W'(1);
        step     = tick && (p_q.cnt == div_last);

        p_d = p_q;
        if (clear)      p_d.cnt = '0;
        else if (step)  p_d.cnt = '0;
        else if (tick)  p_d.cnt = p_q.cnt + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/pwm_chan_frame.sv
module pwm_chan_frame
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clear,
    input  logic              wide,
    input  logic [DUTY_W-1:0] duty,
    input  logic              out_en,
    input  logic              src_pwm,
    input  logic              pattern_in,
    output logic              frame_wrap,
    output logic [CNT_W-1:0]  frame_cnt,
    output logic              pwm_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } frm_st_t;

    frm_st_t          f_q, f_d;
    logic [CNT_W-1:0] last, duty_eff;
    logic             gen_level;

    always_comb begin
        last       = frame_last(wide);
        duty_eff   = duty & last;
        frame_wrap = step && (f_q.cnt >= last);
        gen_level  = (f_q.cnt < duty_eff);

        f_d = f_q;
        if (clear)           f_d.cnt = '0;
        else if (frame_wrap) f_d.cnt = '0;
        else if (step)       f_d.cnt = f_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign frame_cnt = f_q.cnt;
    assign pwm_out   = out_en && (src_pwm ? gen_level : pattern_in);
endmodule

// File: rtl/prescaled_pwm_chan.sv
module prescaled_pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter logic [7:0] SUBTYPE_ID = 8'h11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    input  logic       tick_slow,
    input  logic       tick_mid,
    input  logic       tick_fast,
    input  logic       pattern_in,
    output logic       pwm_out
);
    chan_cfg_t        act_cfg;
    logic             out_en, src_pwm, glitch_en, commit, frame_wrap, step;
    logic [CNT_W-1:0] frame_cnt;

    pwm_chan_regs #(.SUBTYPE_ID(SUBTYPE_ID)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .frame_wrap(frame_wrap), .act_cfg(act_cfg),
        .out_en(out_en), .src_pwm(src_pwm), .glitch_en(glitch_en),
        .commit(commit), .reg_rdata(reg_rdata)
    );

    pwm_chan_prescale u_psc (
        .clk(clk), .rst_n(rst_n),
        .tick_slow(tick_slow), .tick_mid(tick_mid), .tick_fast(tick_fast),
        .csel(act_cfg.csel), .pdiv(act_cfg.pdiv), .expo(act_cfg.expo),
        .clear(commit), .step(step)
    );

    pwm_chan_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .step(step), .clear(commit),
        .wide(act_cfg.wide), .duty(act_cfg.duty),
        .out_en(out_en), .src_pwm(src_pwm), .pattern_in(pattern_in),
        .frame_wrap(frame_wrap), .frame_cnt(frame_cnt), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/prescaled_pwm_chan_chk.sv
module prescaled_pwm_chan_chk
    import pwm_chan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic             pattern_in,
    input logic             pwm_out,
    input logic             out_en,
    input logic             src_pwm,
    input logic             glitch_en,
    input logic             commit,
    input logic             frame_wrap,
    input chan_cfg_t        act_cfg,
    input logic [CNT_W-1:0] frame_cnt
);
    logic mapped;
    assign mapped = (reg_addr == OFS_IDENT) || (reg_addr == OFS_RES) ||
                    (reg_addr == OFS_DIV) || (reg_addr == OFS_MODE) ||
                    (reg_addr == OFS_DUTY_LO) || (reg_addr == OFS_DUTY_HI) ||
                    (reg_addr == OFS_CTRL);

    p_dark_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !pwm_out);

    p_pattern_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !src_pwm) |-> (pwm_out == pattern_in));

    p_last_slot_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && src_pwm && frame_cnt == frame_last(act_cfg.wide)) |-> !pwm_out);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= frame_last(act_cfg.wide));

    p_frozen_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.csel == '0 && !commit) |=> $stable(frame_cnt));

    p_deferred_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && glitch_en && act_cfg.csel != '0) |-> frame_wrap);

    p_restart_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (frame_cnt == '0));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_rdata == 8'h00));
endmodule

bind prescaled_pwm_chan prescaled_pwm_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .pattern_in(pattern_in), .pwm_out(pwm_out), .out_en(out_en),
    .src_pwm(src_pwm), .glitch_en(glitch_en), .commit(commit),
    .frame_wrap(frame_wrap), .act_cfg(act_cfg), .frame_cnt(frame_cnt)
);

// File: tb/prescaled_pwm_chan_tb.sv
`timescale 1ns/1ps
module prescaled_pwm_chan_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata, rdata_b;
    logic       tick_slow = 1'b0, tick_mid = 1'b0, tick_fast = 1'b1;
    logic       pattern_in = 1'b0;
    logic       pwm_out, pwm_out_b;

    int    n_chk = 0, n_fail = 0, tcnt = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    prescaled_pwm_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .tick_slow(tick_slow),
        .tick_mid(tick_mid), .tick_fast(tick_fast), .pattern_in(pattern_in),
        .pwm_out(pwm_out));

    prescaled_pwm_chan #(.SUBTYPE_ID(8'h0B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(rdata_b), .tick_slow(tick_slow),
        .tick_mid(tick_mid), .tick_fast(tick_fast), .pattern_in(pattern_in),
        .pwm_out(pwm_out_b));

    // reference clock enables: slow every 8 cycles, medium every 3, fast always
    always @(negedge clk) begin
        tcnt++;
        tick_slow <= (tcnt % 8 == 0);
        tick_mid  <= (tcnt % 3 == 0);
    end

    // behavioural reference model
    int st_wide, st_csel, st_pdiv, st_exp, st_duty;
    int ac_wide, ac_csel, ac_pdiv, ac_exp, ac_duty;
    int g_on, o_en, o_src, o_ramp, pend, psc, fc;

    function automatic int pf(int c);
        int t[4] = '{1, 3, 5, 6};
        return t[c];
    endfunction

    function automatic int last_of(int w);
        return w ? 511 : 63;
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int tk, divn, step, wrap, sw, cm;
        if (!rst_n) begin
            st_wide = 0; st_csel = 0; st_pdiv = 0; st_exp = 0; st_duty = 0;
            ac_wide = 0; ac_csel = 0; ac_pdiv = 0; ac_exp = 0; ac_duty = 0;
            g_on = 0; o_en = 0; o_src = 0; o_ramp = 0; pend = 0; psc = 0; fc = 0;
        end else begin
            tk   = (ac_csel == 1) ? int'(tick_slow) : (ac_csel == 2) ? int'(tick_mid) :
                   (ac_csel == 3) ? int'(tick_fast) : 0;
            divn = pf(ac_pdiv) * (1 << ac_exp);
            step = (tk != 0) && (psc == divn - 1);
            wrap = step && (fc == last_of(ac_wide));
            sw   = reg_we && reg_addr == 8'h47 && reg_wdata[0];
            cm   = (sw && (!g_on || ac_csel == 0)) || (pend && (wrap || !g_on || ac_csel == 0));
            if (tk != 0) begin
                if (step) begin psc = 0; fc = wrap ? 0 : fc + 1; end
                else psc = psc + 1;
            end
            if (cm) begin
                ac_wide = st_wide; ac_csel = st_csel; ac_pdiv = st_pdiv;
                ac_exp = st_exp; ac_duty = st_duty; psc = 0; fc = 0; pend = 0;
            end else if (sw) pend = 1;
            if (reg_we) begin
                case (reg_addr)
                    8'h41: begin st_wide = reg_wdata[4]; st_csel = reg_wdata[1:0]; end
                    8'h42: begin st_pdiv = reg_wdata[6:5]; st_exp = reg_wdata[2:0]; end
                    8'h43: g_on = reg_wdata[5];
                    8'h44: st_duty = (st_duty & 256) | reg_wdata;
                    8'h45: st_duty = (st_duty & 255) | (reg_wdata[0] ? 256 : 0);
                    8'h46: begin o_en = reg_wdata[7]; o_src = reg_wdata[2]; o_ramp = reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic bit exp_out();
        if (!o_en) return 1'b0;
        if (!o_src) return pattern_in;
        return fc < (ac_duty & last_of(ac_wide));
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            n_chk++;
            if (pwm_out !== exp_out()) begin
                n_fail++;
                $display("FAIL %s model compare at %0t: actual %0b expected %0b",
                         cur_req, $time, pwm_out, exp_out());
            end
        end
    end

    task automatic check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, int expv);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1;
        check(req, $sformatf("read 0x%02h", a), reg_rdata, expv);
    endtask

    task automatic count_high(int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #2;
            h += pwm_out;
        end
    endtask

    task automatic measure_period(output int p);
        bit prev, cur;
        p = -1;
        @(negedge clk); #2; prev = pwm_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #2; cur = pwm_out;
            if (!prev && cur) break;
            prev = cur;
        end
        prev = 1'b1;
        for (int i = 1; i < 5000; i++) begin
            @(negedge clk); #2; cur = pwm_out;
            if (!prev && cur) begin p = i; break; end
            prev = cur;
        end
    endtask

    task automatic setup(int wide, int csel, int pdiv, int ex, int duty, logic [7:0] ctrl);
        wr(8'h43, 8'h00);
        wr(8'h41, 8'((wide << 4) | csel));
        wr(8'h42, 8'((pdiv << 5) | ex));
        wr(8'h44, 8'(duty & 255));
        wr(8'h45, 8'(duty >> 8));
        wr(8'h46, ctrl);
        wr(8'h47, 8'h01);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int h, p, v0;
        do_reset();

        cur_req = "R1";
        check("R1", "pwm_out after reset", pwm_out, 0);
        rd_chk("R1", 8'h05, 8'h11);
        for (int a = 8'h41; a <= 8'h46; a++) rd_chk("R1", 8'(a), 0);

        cur_req = "R2";
        wr(8'h41, 8'hFF); rd_chk("R2", 8'h41, 8'h13);
        wr(8'h42, 8'hFF); rd_chk("R2", 8'h42, 8'h67);
        wr(8'h43, 8'hFF); rd_chk("R2", 8'h43, 8'h20);
        wr(8'h44, 8'hFF); rd_chk("R2", 8'h44, 8'hFF);
        wr(8'h45, 8'hFF); rd_chk("R2", 8'h45, 8'h01);
        wr(8'h46, 8'hFF); rd_chk("R2", 8'h46, 8'h86);
        wr(8'h05, 8'h00); rd_chk("R2", 8'h05, 8'h11);
        rd_chk("R2", 8'h47, 0); rd_chk("R2", 8'h40, 0);
        rd_chk("R2", 8'h48, 0); rd_chk("R2", 8'h00, 0);

        cur_req = "R3";
        do_reset();
        @(negedge clk); reg_addr = 8'h05; #1;
        check("R3", "narrow identity", rdata_b, 8'h0B);
        wr(8'h41, 8'hFF);
        rd_chk("R3", 8'h41, 8'h13);
        check("R3", "narrow variant 0x41", rdata_b, 8'h07);
        wr(8'h41, 8'h04);
        rd_chk("R3", 8'h41, 8'h00);
        check("R3", "narrow variant bit2", rdata_b, 8'h04);

        cur_req = "R4";
        do_reset();
        wr(8'h41, 8'h03); wr(8'h42, 8'h00); wr(8'h44, 8'd16); wr(8'h46, 8'h84);
        count_high(200, h);
        check("R4", "highs before commit", h, 0);

        cur_req = "R5";
        wr(8'h47, 8'h01);
        #2; check("R5", "first cycle after commit", pwm_out, 1);
        count_high(64, h);
        check("R5", "highs per frame duty16", h, 16);

        cur_req = "R7";
        setup(0, 3, 2, 1, 16, 8'h84);
        measure_period(p); check("R7", "period pdiv5 exp1 fast", p, 640);
        count_high(640, h); check("R7", "highs pdiv5 exp1", h, 160);
        setup(0, 2, 3, 0, 8, 8'h84);
        measure_period(p); check("R7", "period pdiv6 mid", p, 1152);

        cur_req = "R8";
        setup(0, 1, 0, 0, 32, 8'h84);
        measure_period(p); check("R8", "period slow clock", p, 512);
        setup(0, 0, 0, 0, 32, 8'h84);
        #2; v0 = pwm_out;
        count_high(100, h);
        check("R8", "frozen output highs", h, v0 * 100);

        cur_req = "R9";
        setup(0, 3, 0, 0, 511, 8'h84);
        count_high(64, h); check("R9", "size6 duty511 lows", 64 - h, 1);
        setup(1, 3, 0, 0, 511, 8'h84);
        count_high(512, h); check("R9", "size9 duty511 lows", 512 - h, 1);
        setup(0, 3, 0, 0, 0, 8'h84);
        count_high(64, h); check("R9", "duty0 highs", h, 0);
        setup(0, 3, 0, 0, 64, 8'h84);
        count_high(64, h); check("R9", "size6 duty64 masked highs", h, 0);

        cur_req = "R6";
        setup(0, 3, 0, 2, 16, 8'h84);
        wr(8'h43, 8'h20); wr(8'h44, 8'd48); wr(8'h47, 8'h01);
        repeat (90) @(negedge clk);
        #2; check("R6", "old duty kept mid-frame", pwm_out, 0);
        repeat (256) @(negedge clk);
        #2; check("R6", "new duty after wrap", pwm_out, 1);

        cur_req = "R10";
        setup(0, 3, 0, 0, 32, 8'h04);
        count_high(64, h); check("R10", "disabled highs", h, 0);
        wr(8'h46, 8'h80);
        @(negedge clk); pattern_in = 1'b1; #2;
        check("R10", "pattern high passthrough", pwm_out, 1);
        @(negedge clk); pattern_in = 1'b0; #2;
        check("R10", "pattern low passthrough", pwm_out, 0);

        cur_req = "R11";
        setup(0, 3, 0, 0, 20, 8'h86);
        rd_chk("R11", 8'h46, 8'h86);
        count_high(64, h); check("R11", "highs with ramp bit set", h, 20);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule